// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a 128K x 8 asynchronous static RAM that has no clock of its own. The host offers one request at a time over a valid/ready handshake (address, write flag, write data). The controller turns each request into a strobe sequence on the RAM pins and returns read data through a one-cycle response pulse. The RAM pins are two chip selects of opposite polarity, a write strobe, an output enable, a 17-bit address and an 8-bit data bus. The data bus is split into an output value, an output-enable and an input value, so the pad ring builds the tristate.

Every minimum time that the RAM needs is held in nanoseconds for the two speed grades, 55 ns and 70 ns. A parameter picks the grade. At elaboration each time is rounded up to whole clock cycles of the configured period. A power-good input handles data retention. While power-good is low, the active-high select is forced low in the same cycle. Once power-good returns, a recovery lockout of millisecond order keeps the host out.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the RAM sits deselected: `ram_cs_n`=1, `ram_cs_hi`=0, `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0 and `rsp_valid`=0. With `pwr_good` high, `req_ready` rises within three clock edges of reset release.
- R2: A write holds `ram_we_n` low for exactly N_WP cycles, with both selects active. N_WP is the ceiling of the longest of the write cycle, strobe width, address-to-end, select-to-end and data-setup times, divided by the clock period. Address and data stay stable throughout. `ram_we_n` rises one cycle before the selects are released, and the written byte is stored at that rising edge.
- R3: `ram_oe_n` stays high whenever `ram_we_n` is low. `ram_dq_oe` is never high while `ram_oe_n` is low.
- R4: A read holds `ram_oe_n` low with both selects active and `ram_we_n` high for exactly N_ACC cycles, where N_ACC is the ceiling of the access time over the clock period. The bus value at the end of the last cycle is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle. `rsp_valid` appears N_ACC+1 cycles after the cycle in which the request was offered.
- R5: After a read, the controller drives no data and selects no access for at least N_DIS cycles, where N_DIS is the ceiling of the output-release time over the clock period.
- R6: Between accesses the RAM is deselected (`ram_cs_n`=1, `ram_cs_hi`=0) and `ram_dq_oe`=0.
- R7: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the access sequence has finished.
- R8: While `pwr_good` is low, `ram_cs_hi` is low in that same cycle, with no clock edge in between, and `req_ready` is low. A read cut short this way gives no `rsp_valid`.
- R9: After `pwr_good` returns high, `req_ready` stays low for N_REC clock edges, where N_REC is the ceiling of RECOVER_US microseconds over the clock period. `ram_cs_hi` stays low throughout.
- R10: Every cycle count is the nanosecond figure of the grade picked by SLOW_GRADE (0: 55 ns grade, 1: 70 ns grade) divided by the clock period and rounded up, and it is never below one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | High while the RAM supply is valid; low requests retention |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| ram_addr | output | 17 | RAM address pins |
| ram_dq_o | output | 8 | Value driven onto the RAM data pins |
| ram_dq_oe | output | 1 | Enables the controller's data-pin drivers |
| ram_dq_i | input | 8 | Value seen on the RAM data pins |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs_hi | output | 1 | Active-high chip select, also the retention control |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low RAM output enable |

## Verification
A wrong state or counter value shows up at the pins within one access. A write strobe or read window of the wrong length appears as a pulse-width mismatch as soon as the strobe rises. A turnaround that is too short shows as the controller driving the bus while the modelled RAM is still releasing it, within two or three cycles of the read. A read sampled too early returns a garbage byte that the bench model presents until the access time has elapsed. A broken recovery counter shows as `req_ready` returning after the wrong number of edges, or `ram_cs_hi` rising during the lockout.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_STROBE,
    ST_WR_CLOSE,
    ST_RD_ACCESS,
    ST_RD_TURN
  } cyc_state_e;

  // ceiling division, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
`timescale 1ns/1ps
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/sram_pwr_guard.sv
`timescale 1ns/1ps
module sram_pwr_guard #(
  parameter int unsigned REC_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic lockout
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!pwr_good) begin
      cnt_d  = CW'(REC_CYC);
      cnt_en = (cnt_q != CW'(REC_CYC));
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign lockout = !pwr_good || (cnt_q != '0);

  AST_REC_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && $past(pwr_good) && ($past(cnt_q) != '0)) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/sram_cycle_fsm.sv
`timescale 1ns/1ps
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_WP   = 6,
  parameter int unsigned N_ACC  = 6,
  parameter int unsigned N_DIS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lockout,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_sel,
  output logic              ram_we_n,
  output logic              ram_oe_n
);
  localparam int unsigned MAXN = max_u(max_u(N_WP, N_ACC), N_DIS);
  localparam int unsigned CW   = $clog2(MAXN + 1);

  cyc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept, capture;
  logic          we_n_d, oe_n_d, sel_d, dq_oe_d;

  assign req_ready = (state_q == ST_IDLE) && !lockout;
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_RD_ACCESS) && (cnt_q == '0) && !lockout;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = req_write ? ST_WR_STROBE : ST_RD_ACCESS;
          cnt_d   = req_write ? CW'(N_WP - 1) : CW'(N_ACC - 1);
        end
      end
      ST_WR_STROBE: begin
        if (lockout) begin
          state_d = ST_RD_TURN;
          cnt_d   = CW'(N_DIS - 1);
        end else if (cnt_q == '0) begin
          state_d = ST_WR_CLOSE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_CLOSE: begin
        state_d = ST_IDLE;
      end
      ST_RD_ACCESS: begin
        if (lockout || (cnt_q == '0)) begin
          state_d = ST_RD_TURN;
          cnt_d   = CW'(N_DIS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RD_TURN: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // pin values decoded from the next state, then registered
  always_comb begin
    we_n_d  = (state_d != ST_WR_STROBE);
    oe_n_d  = (state_d != ST_RD_ACCESS);
    sel_d   = (state_d == ST_WR_STROBE) || (state_d == ST_WR_CLOSE) || (state_d == ST_RD_ACCESS);
    dq_oe_d = (state_d == ST_WR_STROBE) || (state_d == ST_WR_CLOSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_sel   <= 1'b0;
      ram_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      ram_we_n  <= we_n_d;
      ram_oe_n  <= oe_n_d;
      ram_sel   <= sel_d;
      ram_dq_oe <= dq_oe_d;
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr <= '0;
      ram_dq_o <= '0;
    end else if (accept) begin
      ram_addr <= req_addr;
      ram_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (capture) rsp_rdata <= ram_dq_i;
  end

  AST_OE_HI_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n); // R3
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> !ram_dq_oe); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_dq_o))); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_we_n && ram_oe_n && !ram_sel && !ram_dq_oe)); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter bit          SLOW_GRADE    = 1'b0,
  parameter int unsigned RECOVER_US    = 5000,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_cs_n,
  output logic              ram_cs_hi,
  output logic              ram_we_n,
  output logic              ram_oe_n
);
  // grade timings in ns (R10)
  localparam int unsigned T_CYCLE = SLOW_GRADE ? 70 : 55;
  localparam int unsigned T_WPULS = SLOW_GRADE ? 55 : 45;
  localparam int unsigned T_TOEND = SLOW_GRADE ? 65 : 50;
  localparam int unsigned T_DSET  = SLOW_GRADE ? 30 : 25;
  localparam int unsigned T_ACC   = SLOW_GRADE ? 70 : 55;
  localparam int unsigned T_REL   = SLOW_GRADE ? 25 : 20;

  localparam int unsigned N_WP  = ns_to_cyc(max_u(max_u(T_CYCLE, T_WPULS), max_u(T_TOEND, T_DSET)), CLK_PERIOD_NS);
  localparam int unsigned N_ACC = ns_to_cyc(T_ACC, CLK_PERIOD_NS);
  localparam int unsigned N_DIS = ns_to_cyc(T_REL, CLK_PERIOD_NS);
  localparam int unsigned N_REC = ns_to_cyc(RECOVER_US * 1000, CLK_PERIOD_NS);
  localparam int unsigned RW    = $clog2(N_WP + 2);

  logic rst_sync_n;
  logic lockout;
  logic sel_q;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_pwr_guard #(.REC_CYC(N_REC)) u_guard (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_good (pwr_good),
    .lockout  (lockout)
  );

  sram_cycle_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_WP   (N_WP),
    .N_ACC  (N_ACC),
    .N_DIS  (N_DIS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lockout   (lockout),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ram_addr  (ram_addr),
    .ram_dq_o  (ram_dq_o),
    .ram_dq_oe (ram_dq_oe),
    .ram_dq_i  (ram_dq_i),
    .ram_sel   (sel_q),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n)
  );

  // active-high select drops with power-good without waiting for an edge
  assign ram_cs_n  = !sel_q;
  assign ram_cs_hi = sel_q && pwr_good;

  // write strobe run length, used by the width check
  logic [RW-1:0] we_run_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) we_run_q <= '0;
    else if (!ram_we_n) we_run_q <= we_run_q + 1'b1;
    else we_run_q <= '0;
  end

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(ram_we_n) && $past(pwr_good)) |-> (we_run_q == RW'(N_WP))); // R2
  AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ram_we_n && pwr_good) |-> (!ram_cs_n && ram_cs_hi)); // R2
  AST_S2_LOW_IN_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lockout |-> (!ram_cs_hi && !req_ready)); // R9
endmodule

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int REC_US = 1;
  // expected counts for the 55 ns grade, derived here from R10
  localparam int N_WP  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int N_ACC = (55 + CLK_NS - 1) / CLK_NS;
  localparam int N_DIS = (20 + CLK_NS - 1) / CLK_NS;
  localparam int N_REC = (REC_US * 1000 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n, pwr_good, req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic req_ready, rsp_valid, ram_dq_oe, ram_cs_n, ram_cs_hi, ram_we_n, ram_oe_n;
  logic [7:0]  rsp_rdata, ram_dq_o, ram_dq_i;
  logic [16:0] ram_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SLOW_GRADE(1'b0), .RECOVER_US(REC_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i),
    .ram_cs_n(ram_cs_n), .ram_cs_hi(ram_cs_hi), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] mem [int];
  logic sel, ram_drv, wr_pend;
  int   age, tail, wl, ol, gap;
  logic [16:0] age_addr, wa;
  logic [7:0]  wd;
  bit   contention, oe_in_wr, dq_off_in_wr;

  assign sel     = !ram_cs_n && ram_cs_hi;
  assign ram_drv = sel && !ram_oe_n && ram_we_n;

  function automatic logic [7:0] rd_val(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  assign ram_dq_i = (ram_drv && age >= N_ACC) ? rd_val(ram_addr) : 8'hEE;

  initial begin
    age = 0; tail = 0; wl = 0; ol = 0; gap = 1000; wr_pend = 0;
    contention = 0; oe_in_wr = 0; dq_off_in_wr = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      // bus contention: controller drives while the RAM drives or is releasing (R5)
      if (ram_dq_oe && (ram_drv || tail > 0)) contention = 1;
      if (ram_drv) tail = N_DIS; else if (tail > 0) tail--;
      // access age
      if (ram_drv && ram_addr == age_addr && age > 0) age++;
      else if (ram_drv) begin age = 1; age_addr = ram_addr; end
      else age = 0;
      // write capture at strobe rise
      if (!ram_we_n && sel) begin
        wr_pend = 1; wa = ram_addr; wd = ram_dq_o;
        if (!ram_oe_n) oe_in_wr = 1;
        if (!ram_dq_oe) dq_off_in_wr = 1;
      end else if (wr_pend) begin
        mem[int'(wa)] = wd; wr_pend = 0;
      end
      // strobe widths (R2, R4, R10)
      if (!ram_we_n) wl++;
      else if (wl > 0) begin
        chk(wl == N_WP, "R2", "write strobe width", wl, N_WP);
        chk(!oe_in_wr && !dq_off_in_wr, "R3", "oe high and data driven during strobe", oe_in_wr, 0);
        wl = 0; oe_in_wr = 0; dq_off_in_wr = 0;
      end
      if (!ram_oe_n) ol++;
      else if (ol > 0) begin
        if (pwr_good) chk(ol == N_ACC, "R4", "read window width (R10)", ol, N_ACC);
        ol = 0; gap = 0;
      end else if (gap < 1000) begin
        if (sel || ram_dq_oe) begin
          chk(gap >= N_DIS, "R5", "release gap after read", gap, N_DIS);
          gap = 1000;
        end else gap++;
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic host_write(input logic [16:0] a, input logic [7:0] d);
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R7", "ready low while writing", req_ready, 0);
    wait_ready();
    chk(ram_cs_n && !ram_cs_hi && !ram_dq_oe, "R6", "deselected after write",
        {ram_cs_n, ram_cs_hi, ram_dq_oe}, 3'b100);
  endtask

  task automatic host_read(input logic [16:0] a, input logic [7:0] exp);
    int lat;
    logic [7:0] got;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a;
    lat = 0;
    do begin
      @(negedge clk); req_valid = 0; lat++;
    end while (!rsp_valid && lat < 40);
    got = rsp_rdata;
    chk(lat == N_ACC + 1, "R4", "response latency", lat, N_ACC + 1);
    chk(got == exp, "R4", $sformatf("read data @%05h", a), got, exp);
    @(negedge clk);
    chk(!rsp_valid, "R4", "response one cycle", rsp_valid, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 0; pwr_good = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(ram_cs_n && !ram_cs_hi && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid, "R1",
        "pins in reset", {ram_cs_n, ram_cs_hi, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 6'b101100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1", "ready after reset release", req_ready, 1);
    chk(ram_cs_n && !ram_cs_hi, "R1", "deselected after reset", {ram_cs_n, ram_cs_hi}, 2'b10);
  endtask

  task automatic t_idle_no_valid();
    repeat (5) begin
      @(negedge clk);
      if (!ram_cs_n || !ram_we_n || !ram_oe_n) break;
    end
    chk(ram_cs_n && ram_we_n && ram_oe_n, "R7", "no access without valid",
        {ram_cs_n, ram_we_n, ram_oe_n}, 3'b111);
  endtask

  task automatic t_write_read_patterns();
    host_write(17'h00000, 8'hA5);
    host_write(17'h1FFFF, 8'h5A);
    host_write(17'h0ABCD, 8'hFF);
    host_read(17'h00000, 8'hA5);
    host_read(17'h1FFFF, 8'h5A);
    host_read(17'h0ABCD, 8'hFF);
    host_read(17'h12345, 8'h00);
  endtask

  task automatic t_read_then_write();
    host_read(17'h1FFFF, 8'h5A);
    host_write(17'h00001, 8'h3C);   // turnaround checked by the model (R5)
    host_read(17'h00001, 8'h3C);
    host_write(17'h00001, 8'hC3);
    host_read(17'h00001, 8'hC3);
  endtask

  task automatic t_power_abort();
    int n;
    bit cs_seen, rsp_seen;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = 17'h0ABCD;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    pwr_good = 0;
    #1;
    chk(!ram_cs_hi, "R8", "active-high select drops at once", ram_cs_hi, 0);
    chk(!req_ready, "R8", "ready low on power loss", req_ready, 0);
    rsp_seen = 0;
    repeat (6) begin @(negedge clk); if (rsp_valid) rsp_seen = 1; end
    chk(!rsp_seen, "R8", "no response for cut-short read", rsp_seen, 0);
    chk(ram_oe_n && !ram_dq_oe, "R8", "bus quiet while powered down", {ram_oe_n, ram_dq_oe}, 2'b10);
    pwr_good = 1;
    n = 0; cs_seen = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ram_cs_hi) cs_seen = 1;
    end while (!req_ready && n < N_REC + 20);
    chk(n == N_REC, "R9", "recovery lockout length", n, N_REC);
    chk(!cs_seen, "R9", "select low through recovery", cs_seen, 0);
    host_read(17'h0ABCD, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_idle_no_valid();
    t_write_read_patterns();
    t_read_then_write();
    t_power_abort();
    repeat (5) @(negedge clk);
    chk(!contention, "R5", "no bus contention seen", contention, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule